// File: doc/BRIEF.md
# Operand-Width-Gated Integer ALU

This block is a 64-bit integer execution unit that avoids switching its upper datapath whenever an operation can be finished in the low bits alone. Each source operand arrives with a narrow tag. The register file sets that tag when the stored value is the sign extension of its low 16 bits. When both tags are set and the opcode cannot produce a result wider than 17 significant bits, only a 17-bit lower slice computes. The 48-bit upper result register then keeps its previous contents through a clock enable. The final result is rebuilt by sign-extending the 17-bit lower result, so it equals the full-width answer bit for bit.

Operations enter on a valid/ready stream and leave on a second valid/ready stream one cycle later. A single output register sits between the two. The block accepts a new operation whenever that register is empty or is being drained in the same cycle. While the consumer holds ready low, the result stays frozen and no new operation is taken. Each result carries a freshly computed narrow tag, so it can be written back to the register file, and a flag that shows whether the gated path produced it. A free-running counter totals the gated operations.

Top module: `owalu_top`

## Requirements
- R1: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid, result, result_narrow and result_gated hold their values.
- R2: An operation accepted on a clock edge (in_valid and in_ready high) is presented with out_valid high after that edge. With no acceptance and out_ready high, out_valid goes low.
- R3: result equals the exact 64-bit outcome for opcode encodings 0 add, 1 subtract (a minus b), 2 and, 3 or, 4 xor, 5 arithmetic right shift of a by b[5:0], 6 low 64 bits of a times b, and 7 left shift of a by b[5:0]. This holds whether or not gating is applied, including a carry or borrow out of bit 15.
- R4: An accepted operation is gated (result_gated high) exactly when a_narrow and b_narrow are both high and the opcode is one of 0 to 5. A gated operation leaves the upper 48-bit result register unchanged.
- R5: Multiply (6) and left shift (7) always use the full-width path, even when both operands are narrow.
- R6: result_narrow is high exactly when result bits 63 down to 15 are all equal.
- R7: gate_count rises by one on every edge that accepts a gated operation and is otherwise unchanged.
- R8: After reset, out_valid is low and gate_count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op | input | 3 | Opcode, encodings as in R3 |
| a | input | 64 | First source operand |
| a_narrow | input | 1 | a is the sign extension of its low 16 bits |
| b | input | 64 | Second source operand |
| b_narrow | input | 1 | b is the sign extension of its low 16 bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 64 | Operation result |
| result_narrow | output | 1 | Narrow tag of result |
| result_gated | output | 1 | Result came from the gated lower slice |
| gate_count | output | 32 | Running count of gated operations |

## Verification
The assertions assume that the incoming tags are accurate: whenever in_valid is high, a_narrow and b_narrow match the sign-extension test on a and b. A wrong tag would make gating produce a wrong result. The stimulus generates every operand either as a sign-extended 16-bit value or as a full 64-bit random value, and derives its tag from the value. It also mixes narrow and wide operands and varies out_ready to cover the gated, full-width and stalled cases.

// File: rtl/owalu_pkg.sv
package owalu_pkg;
  localparam int unsigned OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SRA = 3'd5,
    OP_MUL = 3'd6,
    OP_SLL = 3'd7
  } alu_op_e;

  // Opcodes whose result never needs more than one bit above the narrow width
  function automatic logic op_fits_low(alu_op_e o);
    return (o != OP_MUL) && (o != OP_SLL);
  endfunction
endpackage

// File: rtl/owalu_tag.sv
module owalu_tag #(
  parameter int unsigned DW = 64,
  parameter int unsigned NW = 16
) (
  input  logic [DW-1:0] value,
  output logic          narrow
);
  localparam int unsigned TOP_W = DW - NW + 1;
  logic [TOP_W-1:0] top_bits;

  assign top_bits = value[DW-1:NW-1];
  assign narrow   = (&top_bits) | ~(|top_bits);
endmodule

// File: rtl/owalu_lo.sv
module owalu_lo
  import owalu_pkg::*;
#(
  parameter int unsigned NW  = 16,
  parameter int unsigned SHW = 6
) (
  input  alu_op_e        op,
  input  logic [NW-1:0]  a,
  input  logic [NW-1:0]  b,
  input  logic [SHW-1:0] shamt,
  output logic [NW:0]    y
);
  localparam int unsigned LW = NW + 1;

  logic [LW-1:0]  a_x, b_x;
  logic [SHW-1:0] sh_c;

  assign a_x  = {a[NW-1], a};
  assign b_x  = {b[NW-1], b};
  assign sh_c = (shamt >= SHW'(NW)) ? SHW'(NW) : shamt;

  always_comb begin
    unique case (op)
      OP_ADD:  y = a_x + b_x;
      OP_SUB:  y = a_x - b_x;
      OP_AND:  y = a_x & b_x;
      OP_OR:   y = a_x | b_x;
      OP_XOR:  y = a_x ^ b_x;
      OP_SRA:  y = LW'($signed(a_x) >>> sh_c);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/owalu_full.sv
module owalu_full
  import owalu_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam int unsigned SHW = $clog2(DW);

  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SRA:  y = DW'($signed(a) >>> sh);
      OP_MUL:  y = a * b;
      OP_SLL:  y = a << sh;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/owalu_top.sv
module owalu_top
  import owalu_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned NW = 16,
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic          a_narrow,
  input  logic [DW-1:0] b,
  input  logic          b_narrow,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result,
  output logic          result_narrow,
  output logic          result_gated,
  output logic [CW-1:0] gate_count
);
  localparam int unsigned HW  = DW - NW;
  localparam int unsigned LW  = NW + 1;
  localparam int unsigned SHW = $clog2(DW);
  localparam int unsigned XW  = DW - LW;

  alu_op_e       op_e;
  logic          accept;
  logic          gate;
  logic [LW-1:0] lo_y;
  logic [DW-1:0] full_y;

  logic [LW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic          gated_q;
  logic          valid_q;

  assign op_e     = alu_op_e'(op);
  assign in_ready = ~valid_q | out_ready;
  assign accept   = in_valid & in_ready;
  assign gate     = a_narrow & b_narrow & op_fits_low(op_e);

  owalu_lo #(.NW(NW), .SHW(SHW)) lo_i (
    .op    (op_e),
    .a     (a[NW-1:0]),
    .b     (b[NW-1:0]),
    .shamt (b[SHW-1:0]),
    .y     (lo_y)
  );

  owalu_full #(.DW(DW)) full_i (
    .op (op_e),
    .a  (a),
    .b  (b),
    .y  (full_y)
  );

  // Lower slice register: always loaded on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      gated_q <= 1'b0;
    end else if (accept) begin
      lo_q    <= gate ? lo_y : {1'b0, full_y[NW-1:0]};
      gated_q <= gate;
    end
  end

  // Upper slice register: clock enable is low for gated operations
  logic hi_en;
  assign hi_en = accept & ~gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (hi_en) hi_q <= full_y[DW-1:NW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else if (accept) valid_q <= 1'b1;
    else if (out_ready) valid_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_count <= '0;
    else if (accept && gate) gate_count <= gate_count + 1'b1;
  end

  assign result = gated_q ? {{XW{lo_q[LW-1]}}, lo_q} : {hi_q, lo_q[NW-1:0]};

  owalu_tag #(.DW(DW), .NW(NW)) res_tag_i (
    .value  (result),
    .narrow (result_narrow)
  );

  assign out_valid    = valid_q;
  assign result_gated = gated_q;
endmodule

// File: rtl/owalu_chk.sv
module owalu_chk #(
  parameter int unsigned DW = 64,
  parameter int unsigned NW = 16,
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    op,
  input logic [DW-1:0] a,
  input logic          a_narrow,
  input logic [DW-1:0] b,
  input logic          b_narrow,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] result,
  input logic          result_narrow,
  input logic          result_gated,
  input logic [CW-1:0] gate_count,
  input logic [DW-NW-1:0] hi_q
);
  logic acc;
  logic low_op;
  assign acc    = in_valid && in_ready;
  assign low_op = (op != 3'd6) && (op != 3'd7);

  // Input assumption: tags describe the operand values
  a_r4_tags_true: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (a_narrow == ($signed(a) == $signed({{(DW-NW){a[NW-1]}}, a[NW-1:0]}))) &&
                 (b_narrow == ($signed(b) == $signed({{(DW-NW){b[NW-1]}}, b[NW-1:0]}))));

  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(result_gated));

  a_r1_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r4_wide_not_gated: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !(a_narrow && b_narrow) |=> !result_gated);

  a_r4_narrow_gated: assert property (@(posedge clk) disable iff (!rst_n)
    acc && a_narrow && b_narrow && low_op |=> result_gated);

  a_r4_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    acc && a_narrow && b_narrow && low_op |=> $stable(hi_q));

  a_r5_full_path: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !low_op |=> !result_gated);

  a_r6_tag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> result_narrow == ((result[DW-1:NW-1] == '0) || (result[DW-1:NW-1] == '1)));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && a_narrow && b_narrow && low_op |=> gate_count == $past(gate_count) + 1'b1);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && a_narrow && b_narrow && low_op) |=> $stable(gate_count));
endmodule

bind owalu_top owalu_chk #(.DW(DW), .NW(NW), .CW(CW)) chk_i (.*);

// File: tb/owalu_top_tb_top.sv
`timescale 1ns/1ps
module owalu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic        a_narrow = 1'b0, b_narrow = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic        result_narrow, result_gated;
  logic [31:0] gate_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit          m_valid = 0;
  logic [63:0] m_result = '0;
  bit          m_gated = 0;
  longint unsigned m_count = 0;

  always #4 clk = ~clk;

  owalu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .a(a), .a_narrow(a_narrow), .b(b), .b_narrow(b_narrow),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .result_narrow(result_narrow), .result_gated(result_gated),
    .gate_count(gate_count)
  );

  function automatic bit is_narrow(logic [63:0] v);
    return ($signed(v) >= -64'sd32768) && ($signed(v) <= 64'sd32767);
  endfunction

  function automatic logic [63:0] ref_op(logic [2:0] o, logic [63:0] x, logic [63:0] y);
    int sh;
    sh = int'(y[5:0]);
    case (o)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      3'd5: return $signed(x) >>> sh;
      3'd6: return x * y;
      default: return x << sh;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_outputs();
    check(out_valid == m_valid, "R2 out_valid", 64'(out_valid), 64'(m_valid));
    check(gate_count == m_count[31:0], "R7 gate_count", 64'(gate_count), m_count);
    if (m_valid) begin
      check(result == m_result, "R3 result", result, m_result);
      check(result_gated == m_gated, "R4/R5 result_gated", 64'(result_gated), 64'(m_gated));
      check(result_narrow == is_narrow(m_result), "R6 result_narrow",
            64'(result_narrow), 64'(is_narrow(m_result)));
    end
  endtask

  // One cycle: check state, drive inputs, advance the model
  task automatic step(bit v, logic [2:0] o, logic [63:0] x, logic [63:0] y, bit rdy);
    bit exp_ready;
    bit g;
    @(negedge clk);
    compare_outputs();
    in_valid = v; op = o; a = x; b = y;
    a_narrow = is_narrow(x); b_narrow = is_narrow(y);
    out_ready = rdy;
    #1;
    exp_ready = !m_valid || rdy;
    check(in_ready == exp_ready, "R1 in_ready", 64'(in_ready), 64'(exp_ready));
    if (v && exp_ready) begin
      g = is_narrow(x) && is_narrow(y) && (o != 3'd6) && (o != 3'd7);
      m_valid = 1; m_result = ref_op(o, x, y); m_gated = g;
      if (g) m_count++;
    end else if (rdy) begin
      m_valid = 0;
    end
  endtask

  function automatic logic [63:0] rnd_val(bit nar);
    logic [15:0] s;
    s = 16'($urandom);
    if (nar) return {{48{s[15]}}, s};
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 1'b0, "R8 out_valid in reset", 64'(out_valid), 64'd0);
    check(gate_count == 32'd0, "R8 gate_count in reset", 64'(gate_count), 64'd0);
    rst_n = 1'b1;

    // R3/R4 carry out of bit 15 on the gated path
    step(1, 3'd0, 64'd32767, 64'd32767, 1);
    // R3 borrow below -32768 on the gated path
    step(1, 3'd1, 64'hFFFF_FFFF_FFFF_8000, 64'd1, 1);
    // R3 gated arithmetic shift with a large amount
    step(1, 3'd5, 64'hFFFF_FFFF_FFFF_8001, 64'd40, 1);
    step(1, 3'd5, 64'd12345, 64'd3, 1);
    // R5 narrow multiply and left shift go full width
    step(1, 3'd6, 64'd30000, 64'hFFFF_FFFF_FFFF_8ACF, 1);
    step(1, 3'd7, 64'd1, 64'd40, 1);
    // R4 one wide operand disables gating
    step(1, 3'd0, 64'h1234_5678_9ABC_DEF0, 64'd5, 1);
    // R4 upper register unused by gated op: wide then gated then wide results
    step(1, 3'd4, 64'hFFFF_FFFF_FFFF_FFF0, 64'd15, 1);
    step(1, 3'd2, 64'hAAAA_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    // R1 stall holds result
    step(1, 3'd3, 64'd7, 64'd8, 0);
    step(1, 3'd0, 64'd1, 64'd2, 0);
    step(1, 3'd0, 64'd1, 64'd2, 0);
    step(1, 3'd0, 64'd1, 64'd2, 1);
    step(0, 3'd0, 64'd0, 64'd0, 1);
    step(0, 3'd0, 64'd0, 64'd0, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] o;
      o = 3'($urandom);
      step(($urandom % 5) != 0, o, rnd_val(($urandom % 3) != 0),
           rnd_val(($urandom % 3) != 0), ($urandom % 4) != 0);
    end
    step(0, 3'd0, 64'd0, 64'd0, 1);
    @(negedge clk);
    compare_outputs();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule